// File: doc/BRIEF.md
# Tamper Response and Zeroization Controller

This block lives in an always-on, low-power domain and guards a small retention memory against physical tampering. Software configures it through one control word. The word holds a detection enable, a wake-on-tamper enable, a two-bit zeroization region select and a write-one-to-clear acknowledge bit. A write qualifier and a lock input can both veto any update. When detection is enabled and a rising edge is seen on the tamper input, the block latches a tamper event. It then immediately wipes the chosen part of its 16-word retention memory, one word per clock, from the lowest address of the region upward. While the event is latched and wake-on-tamper is set, it drives a wake request.

The retention memory also has an ordinary single-word read/write port. This port is shut off for as long as zeroization runs, so data cannot be read out or written back mid-wipe. An acknowledge written during the wipe is held back and takes effect only once the last word has been cleared.

Top module: `tamper_zeroize_ctrl`

## Requirements
- R1: After reset the control readback is 0, and `tamper_event`, `wake_req`, `clr_busy` and `mem_rdata` are all 0.
- R2: A qualified write stores detection enable at bit 0, region select at bits 9:8 and wake enable at bit 11. All other readback bits are 0, including the acknowledge bit 4.
- R3: A control write made while `wr_ready` is 0 leaves the register and the event unchanged.
- R4: A control write made while `regs_locked` is 1 leaves the register and the event unchanged.
- R5: A rising edge on `tamper_in` latches `tamper_event` at the next clock only if detection is enabled. With detection disabled the edge is ignored.
- R6: While an event is latched, further tamper edges neither restart zeroization nor touch memory.
- R7: Region select 0 clears nothing; 1 clears words 0 to 7; 2 clears words 8 to 15; 3 clears words 0 to 15. One word is cleared per clock, and `clr_busy` stays high for exactly the number of words cleared, starting in the cycle the event latches.
- R8: `wake_req` is 1 exactly when an event is latched and the wake-enable bit is 1.
- R9: Writing 1 to bit 4 while zeroization is idle clears `tamper_event` at that clock edge.
- R10: An acknowledge written while zeroization is busy keeps `tamper_event` high until `clr_busy` has fallen, and clears it one clock later.
- R11: While `clr_busy` is 1, memory-port writes are discarded and memory-port reads return 0.
- R12: A memory-port read returns the addressed word on `mem_rdata` one clock after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 32 | Control register write value |
| wr_ready | input | 1 | Write qualifier; writes are dropped when low |
| regs_locked | input | 1 | Lock; writes are dropped when high |
| reg_rd_data | output | 32 | Control register readback |
| tamper_in | input | 1 | Synchronised, filtered tamper signal |
| mem_req | input | 1 | Memory port request |
| mem_we | input | 1 | Memory port write (1) or read (0) |
| mem_addr | input | 4 | Memory port word address |
| mem_wdata | input | 32 | Memory port write data |
| mem_rdata | output | 32 | Memory port read data, one cycle after the request |
| tamper_event | output | 1 | Latched tamper event |
| wake_req | output | 1 | Wake request to the power controller |
| clr_busy | output | 1 | Zeroization in progress |

## Verification
The hardest situation to reach is the overlap of an acknowledge and a memory access with a wipe that is still running. The bench arms a full-memory clear, which gives the longest window. A few clocks after the event latches, it issues a write to a word that has already been wiped, an acknowledge, and a read of a word not yet wiped. It then watches the event across the falling edge of `clr_busy`. Finally it reads back the targeted word to show the blocked write left no trace.

// File: rtl/tzc_pkg.sv
// Shared types and control-word bit positions for the tamper zeroization controller.
// Assumes a control word of at least 12 bits.
package tzc_pkg;

    typedef enum logic [1:0] {
        ZSEL_NONE = 2'd0,
        ZSEL_LOW  = 2'd1,
        ZSEL_HIGH = 2'd2,
        ZSEL_ALL  = 2'd3
    } zsel_e;

    typedef struct packed {
        logic  wake_en;
        zsel_e zsel;
        logic  det_en;
    } tz_cfg_t;

    localparam int POS_DET  = 0;
    localparam int POS_ACK  = 4;
    localparam int POS_ZSEL = 8;
    localparam int POS_WAKE = 11;

endpackage

// File: rtl/tzc_cfg_reg.sv
// Control register: holds detection enable, region select and wake enable.
// Produces a one-cycle acknowledge pulse for bit 4 writes.
// Assumes the write strobe is already in this clock domain; qualifier and lock gate every write.
module tzc_cfg_reg
    import tzc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_ready,
    input  logic              locked,
    input  logic [DATA_W-1:0] wr_data,
    output tz_cfg_t           cfg,
    output logic              ack_pulse,
    output logic [DATA_W-1:0] rd_data
);

    logic wr_ok;
    logic unused_wr_bits;

    assign wr_ok          = wr_en && wr_ready && !locked;
    assign unused_wr_bits = ^wr_data;

    // Capture the configuration fields on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_ok) begin
            cfg.det_en  <= wr_data[POS_DET];
            cfg.zsel    <= zsel_e'(wr_data[POS_ZSEL +: 2]);
            cfg.wake_en <= wr_data[POS_WAKE];
        end
    end

    // Acknowledge strobe: only on a qualified write with bit 4 set.
    assign ack_pulse = wr_ok && wr_data[POS_ACK];

    // Readback: configured fields only, everything else zero.
    always_comb begin
        rd_data                 = '0;
        rd_data[POS_DET]        = cfg.det_en;
        rd_data[POS_ZSEL +: 2]  = cfg.zsel;
        rd_data[POS_WAKE]       = cfg.wake_en;
    end

endmodule

// File: rtl/tzc_event.sv
// Tamper event latch: detects a rising edge on the tamper input and latches an event.
// Defers an acknowledge that arrives while zeroization is active.
// Assumes tamper_in is already synchronised and filtered.
module tzc_event (
    input  logic clk,
    input  logic rst_n,
    input  logic tamper_in,
    input  logic det_en,
    input  logic ack_pulse,
    input  logic seq_busy,
    output logic event_q,
    output logic detect
);

    logic tamper_q;
    logic ack_pend;
    logic rise;

    // Previous tamper level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) tamper_q <= 1'b0;
        else        tamper_q <= tamper_in;
    end

    assign rise   = tamper_in && !tamper_q;
    assign detect = rise && det_en && !event_q;

    // Remember an acknowledge that cannot be applied yet.
    always_ff @(posedge clk) begin
        if (!rst_n)                                ack_pend <= 1'b0;
        else if (ack_pulse && (seq_busy || detect)) ack_pend <= 1'b1;
        else if (ack_pend && !seq_busy)            ack_pend <= 1'b0;
    end

    // Event latch: set on detection; cleared by an acknowledge once idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       event_q <= 1'b0;
        else if (detect)                                  event_q <= 1'b1;
        else if ((ack_pulse || ack_pend) && !seq_busy)    event_q <= 1'b0;
    end

endmodule

// File: rtl/tzc_zero_seq.sv
// Zeroization sequencer: on start, walks the selected region one word per clock from its lowest address.
// Assumes WORDS is even; the region is captured at start and cannot change mid-run.
module tzc_zero_seq
    import tzc_pkg::*;
#(
    parameter int WORDS  = 16,
    parameter int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  zsel_e             zsel,
    output logic              busy,
    output logic [ADDR_W-1:0] waddr
);

    localparam int HALF = WORDS / 2;
    localparam logic [ADDR_W-1:0] A_FIRST = '0;
    localparam logic [ADDR_W-1:0] A_MID   = ADDR_W'(HALF);
    localparam logic [ADDR_W-1:0] A_LOWE  = ADDR_W'(HALF - 1);
    localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(WORDS - 1);

    logic [ADDR_W-1:0] last_q;
    logic [ADDR_W-1:0] first_d;
    logic [ADDR_W-1:0] last_d;
    logic              go_d;

    // Decode the region bounds from the select field.
    always_comb begin
        go_d    = 1'b1;
        first_d = A_FIRST;
        last_d  = A_LAST;
        case (zsel)
            ZSEL_NONE: go_d = 1'b0;
            ZSEL_LOW:  last_d = A_LOWE;
            ZSEL_HIGH: first_d = A_MID;
            default:   ;
        endcase
    end

    // Walk the region: load bounds on start, step until the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            waddr  <= '0;
            last_q <= '0;
        end else if (start && !busy) begin
            busy   <= go_d;
            waddr  <= first_d;
            last_q <= last_d;
        end else if (busy) begin
            if (waddr == last_q) busy  <= 1'b0;
            else                 waddr <= waddr + 1'b1;
        end
    end

endmodule

// File: rtl/tzc_ret_mem.sv
// Retention memory: word storage with a zeroization write path and a gated access port.
// Storage is not reset (it is retained); the read register is reset.
module tzc_ret_mem #(
    parameter int WORDS  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zero_en,
    input  logic [ADDR_W-1:0] zero_addr,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        // One storage word: zeroization wins, port writes only when idle.
        always_ff @(posedge clk) begin
            if (zero_en && (zero_addr == ADDR_W'(g)))
                words[g] <= '0;
            else if (!zero_en && req && we && (addr == ADDR_W'(g)))
                words[g] <= wdata;
        end
    end

    // Registered read port; returns zero while zeroization is active.
    always_ff @(posedge clk) begin
        if (!rst_n)             rdata <= '0;
        else if (req && !we)    rdata <= zero_en ? '0 : words[addr];
    end

endmodule

// File: rtl/tamper_zeroize_ctrl.sv
// Top of the tamper zeroization controller: control register, event latch, region sequencer, memory.
// Assumes a single always-on clock; synchronisation and filtering of tamper_in are done upstream.
module tamper_zeroize_ctrl
    import tzc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WORDS  = 16,
    parameter int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic              wr_ready,
    input  logic              regs_locked,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic              tamper_in,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] mem_rdata,
    output logic              tamper_event,
    output logic              wake_req,
    output logic              clr_busy
);

    tz_cfg_t           cfg;
    logic              ack_pulse;
    logic              detect;
    logic [ADDR_W-1:0] zaddr;

    tzc_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_ready  (wr_ready),
        .locked    (regs_locked),
        .wr_data   (reg_wr_data),
        .cfg       (cfg),
        .ack_pulse (ack_pulse),
        .rd_data   (reg_rd_data)
    );

    tzc_event u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tamper_in (tamper_in),
        .det_en    (cfg.det_en),
        .ack_pulse (ack_pulse),
        .seq_busy  (clr_busy),
        .event_q   (tamper_event),
        .detect    (detect)
    );

    tzc_zero_seq #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (detect),
        .zsel  (cfg.zsel),
        .busy  (clr_busy),
        .waddr (zaddr)
    );

    tzc_ret_mem #(.WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .zero_en   (clr_busy),
        .zero_addr (zaddr),
        .req       (mem_req),
        .we        (mem_we),
        .addr      (mem_addr),
        .wdata     (mem_wdata),
        .rdata     (mem_rdata)
    );

    // Wake request follows the latched event, gated by the wake enable.
    assign wake_req = tamper_event && cfg.wake_en;

endmodule

// File: rtl/tzc_checker.sv
// Property checker for the tamper zeroization controller, observing top-level ports only.
module tzc_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic              wr_ready,
    input logic              regs_locked,
    input logic [DATA_W-1:0] reg_rd_data,
    input logic              mem_req,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              tamper_event,
    input logic              wake_req,
    input logic              clr_busy
);

    p_unready_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !wr_ready) |=> $stable(reg_rd_data));

    p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && regs_locked) |=> $stable(reg_rd_data));

    p_event_needs_det_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tamper_event) |-> $past(reg_rd_data[0]));

    p_single_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_busy) |-> $rose(tamper_event));

    p_busy_has_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy |-> tamper_event);

    p_wake_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (tamper_event && reg_rd_data[11]));

    p_defer_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tamper_event && clr_busy) |=> tamper_event);

    p_blocked_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_busy && mem_req && !mem_we) |=> (mem_rdata == '0));

endmodule

bind tamper_zeroize_ctrl tzc_checker #(.DATA_W(DATA_W)) u_tzc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .wr_ready     (wr_ready),
    .regs_locked  (regs_locked),
    .reg_rd_data  (reg_rd_data),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_rdata    (mem_rdata),
    .tamper_event (tamper_event),
    .wake_req     (wake_req),
    .clr_busy     (clr_busy)
);

// File: tb/tb_tamper_zeroize_ctrl.sv
module tb_tamper_zeroize_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic        wr_ready = 1'b1;
    logic        regs_locked = 1'b0;
    logic [31:0] reg_rd_data;
    logic        tamper_in = 1'b0;
    logic        mem_req = 1'b0;
    logic        mem_we = 1'b0;
    logic [3:0]  mem_addr = '0;
    logic [31:0] mem_wdata = '0;
    logic [31:0] mem_rdata;
    logic        tamper_event;
    logic        wake_req;
    logic        clr_busy;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    tamper_zeroize_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .wr_ready(wr_ready), .regs_locked(regs_locked), .reg_rd_data(reg_rd_data),
        .tamper_in(tamper_in), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tamper_event(tamper_event),
        .wake_req(wake_req), .clr_busy(clr_busy)
    );

    // Vector: [9:8] region select, [7] wake enable, [6:2] expected busy cycles,
    // [1] lower half expected cleared, [0] upper half expected cleared.
    localparam logic [9:0] VEC [4] = '{
        {2'd0, 1'b1, 5'd0,  1'b0, 1'b0},
        {2'd1, 1'b0, 5'd8,  1'b1, 1'b0},
        {2'd2, 1'b1, 5'd8,  1'b0, 1'b1},
        {2'd3, 1'b0, 5'd16, 1'b1, 1'b1}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wr_data = d;
        tick();
        reg_wr_en = 1'b0; reg_wr_data = '0;
    endtask

    task automatic mem_write(input logic [3:0] a, input logic [31:0] d);
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = a; mem_wdata = d;
        tick();
        mem_req = 1'b0; mem_we = 1'b0;
    endtask

    task automatic mem_read(input logic [3:0] a, output logic [31:0] d);
        mem_req = 1'b1; mem_we = 1'b0; mem_addr = a;
        tick();
        d = mem_rdata;
        mem_req = 1'b0;
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'hA5C3_0000 | 32'(i);
    endfunction

    initial begin
        #(4ns * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          cnt;
        logic [31:0] cfgw;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 ctrl", reg_rd_data, 32'h0);
        check("R1 event", {31'b0, tamper_event}, 32'h0);
        check("R1 wake", {31'b0, wake_req}, 32'h0);
        check("R1 busy", {31'b0, clr_busy}, 32'h0);
        check("R1 rdata", mem_rdata, 32'h0);

        // R2 field positions, reserved and acknowledge bits read 0
        reg_write(32'hFFFF_FFFF);
        check("R2 readback", reg_rd_data, 32'h0000_0B01);
        // R3 qualifier low drops the write
        wr_ready = 1'b0; reg_write(32'h0); wr_ready = 1'b1;
        check("R3 unready", reg_rd_data, 32'h0000_0B01);
        // R4 lock drops the write
        regs_locked = 1'b1; reg_write(32'h0); regs_locked = 1'b0;
        check("R4 locked", reg_rd_data, 32'h0000_0B01);
        reg_write(32'h0);

        // R5 edge with detection disabled is ignored
        tamper_in = 1'b1; tick(); tick();
        check("R5 disabled", {31'b0, tamper_event}, 32'h0);
        tamper_in = 1'b0; tick();

        // Region vectors: R5, R7, R8, R9, R12
        foreach (VEC[v]) begin
            for (int i = 0; i < 16; i++) mem_write(4'(i), pat(i));
            cfgw = 32'h1 | (32'(VEC[v][9:8]) << 8) | (32'(VEC[v][7]) << 11);
            reg_write(cfgw);
            tamper_in = 1'b1; tick();
            check("R5 latch", {31'b0, tamper_event}, 32'h1);
            check("R8 wake", {31'b0, wake_req}, {31'b0, VEC[v][7]});
            cnt = 0;
            while (clr_busy && cnt < 40) begin cnt++; tick(); end
            check("R7 busy cycles", 32'(cnt), 32'(VEC[v][6:2]));
            for (int i = 0; i < 16; i++) begin
                mem_read(4'(i), rd);
                check("R7 R12 word", rd,
                      ((i < 8) ? VEC[v][1] : VEC[v][0]) ? 32'h0 : pat(i));
            end
            reg_write(cfgw | 32'h10);
            check("R9 ack clears", {31'b0, tamper_event}, 32'h0);
            check("R8 wake drops", {31'b0, wake_req}, 32'h0);
            tamper_in = 1'b0; tick();
        end

        // R6 extra edges while latched are ignored
        reg_write(32'h0000_0101);
        tamper_in = 1'b1; tick();
        while (clr_busy) tick();
        mem_write(4'd0, 32'h0000_1234);
        tamper_in = 1'b0; tick();
        tamper_in = 1'b1; tick(); tick();
        check("R6 no restart", {30'b0, tamper_event, clr_busy}, 32'h2);
        mem_read(4'd0, rd);
        check("R6 memory kept", rd, 32'h0000_1234);
        reg_write(32'h0000_0111);
        tamper_in = 1'b0; tick();

        // R10 / R11 acknowledge and access during a full wipe
        for (int i = 0; i < 16; i++) mem_write(4'(i), pat(i));
        reg_write(32'h0000_0B01);
        tamper_in = 1'b1; tick();
        repeat (3) tick();
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = 4'd0; mem_wdata = 32'hDEAD_BEEF;
        reg_wr_en = 1'b1; reg_wr_data = 32'h0000_0B11;
        tick();
        reg_wr_en = 1'b0; mem_req = 1'b0; mem_we = 1'b0;
        check("R10 held after ack", {31'b0, tamper_event}, 32'h1);
        mem_read(4'd15, rd);
        check("R11 blocked read", rd, 32'h0);
        while (clr_busy) tick();
        check("R10 held at busy fall", {31'b0, tamper_event}, 32'h1);
        tick();
        check("R10 cleared after", {31'b0, tamper_event}, 32'h0);
        mem_read(4'd0, rd);
        check("R11 blocked write", rd, 32'h0);
        tamper_in = 1'b0; tick();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule